// File: doc/BRIEF.md
# Addend-Driven Precision Time Counter

This block is the time base for a precision time protocol timestamp unit. It holds a 64-bit system time count, split into a low word and a high word. The count does not step on every clock. Each reference clock adds a programmable addend into a fixed-width accumulator, and only a carry out of that accumulator advances the count. Software can therefore trim the clock rate in very fine steps. One count stands for 32 ns, so software turns a count into nanoseconds by shifting it left by five. The default addend is 0xA0000000. Software derives a trimmed addend as default ± default × ppb / 10^9, for corrections of up to ±50,000,000 ppb.

Software reaches the block over a simple register bus. A read strobe on the low time word captures the high word, which makes a two-word read coherent. A write to the high time word loads the full 64-bit value, using the low word from the previous low-word write. A programmable maximum sets where the low word wraps into the high word. This maximum is protected by a separate enable register. When the count reaches or passes a 64-bit target, the block sends a one-cycle pulse to the event logic. A control bit holds the whole block in its reset state while it is set.

Top module: `ptc_top`

## Requirements
- R1: After reset, the registers hold these values: addend 0xA0000000, accumulator 0, time 0, target low word 1, target high word 0, low-word maximum 0xFFFFFFFF, maximum enable 0, control 0. Bus offsets are: 0 control (bit 0 = block reset), 1 addend, 2 accumulator, 3 time low, 4 time high, 5 target low, 6 target high, 7 maximum enable (bit 0), 8 low-word maximum. Reads from unused offsets return 0.
- R2: On every clock, the accumulator becomes (accumulator + addend) mod 2^32. When that sum carries out of bit 31, the system time goes up by one on the same edge.
- R3: A new addend written on an edge takes part in accumulation from the following edge onward. The accumulation on the write edge itself uses the old addend.
- R4: A read strobe at offset 3 returns the live low word. On that edge it copies the live high word into a shadow. A read at offset 4 returns the shadow.
- R5: A write to offset 3 only stores a pending low word. A write to offset 4 loads time = {written word, pending low word} and takes priority over an increment on that edge.
- R6: An increment with the low word equal to the programmed maximum sets the low word to 0 and increments the high word.
- R7: A write to offset 8 changes the maximum only while the maximum enable register holds 1. Otherwise the write is ignored.
- R8: On the first cycle that the unsigned 64-bit time is at or above the target, `tgt_hit` is high for exactly one cycle. The pulse re-arms only after time drops below the target.
- R9: While control bit 0 is 1, every other register is held at its R1 value and writes to other offsets are ignored. After bit 0 is cleared, counting resumes from zero.
- R10: A write to offset 2 replaces the accumulator value and suppresses the carry on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current offset (combinational) |
| tgt_hit | output | 1 | One-cycle pulse when time reaches the target |

## Verification
The assertions assume that a read strobe and a write strobe are never active in the same cycle. They also assume that every strobe lasts one cycle at a register offset. The bench drives each access in its own cycle from a task, with both strobes low between accesses. The properties also take the reset-hold bit as the only thing that may move time away from an increment or a load. For this reason the stimulus never changes time other than through the bus or the accumulator. Before every exact timing check, the stimulus freezes the count by writing a zero addend. It then starts the count again with an all-ones addend and a full accumulator, so the count advances on every cycle.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   localparam int unsigned ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_CTRL    = 4'h0;
   localparam logic [ADDR_W-1:0] A_ADDEND  = 4'h1;
   localparam logic [ADDR_W-1:0] A_ACCUM   = 4'h2;
   localparam logic [ADDR_W-1:0] A_TIME_LO = 4'h3;
   localparam logic [ADDR_W-1:0] A_TIME_HI = 4'h4;
   localparam logic [ADDR_W-1:0] A_TGT_LO  = 4'h5;
   localparam logic [ADDR_W-1:0] A_TGT_HI  = 4'h6;
   localparam logic [ADDR_W-1:0] A_MAX_EN  = 4'h7;
   localparam logic [ADDR_W-1:0] A_MAX     = 4'h8;
endpackage

// File: rtl/ptc_accum.sv
// Fractional accumulator: the carry out is the count enable for system time.
module ptc_accum #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] addend,
   input  logic         acc_wr,
   input  logic [W-1:0] acc_wdata,
   output logic [W-1:0] acc_q,
   output logic         carry
);
   logic [W:0] sum;

   always_comb begin
      sum   = {1'b0, acc_q} + {1'b0, addend};
      carry = sum[W] & ~hold & ~acc_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (hold)   acc_q <= '0;
      else if (acc_wr) acc_q <= acc_wdata;
      else             acc_q <= sum[W-1:0];
   end
endmodule

// File: rtl/ptc_timectr.sv
// Two-word time count with a programmable low-word wrap point.
module ptc_timectr #(
   parameter int unsigned W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic           inc,
   input  logic [W-1:0]   lomax,
   input  logic           ld,
   input  logic [2*W-1:0] ld_val,
   output logic [W-1:0]   lo,
   output logic [W-1:0]   hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo <= '0;
         hi <= '0;
      end else if (hold) begin
         lo <= '0;
         hi <= '0;
      end else if (ld) begin
         lo <= ld_val[W-1:0];
         hi <= ld_val[2*W-1:W];
      end else if (inc) begin
         if (lo == lomax) begin
            lo <= '0;
            hi <= hi + 1'b1;
         end else begin
            lo <= lo + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ptc_cmp.sv
// Target comparator with edge detection; REG_STAGE adds a pipeline flop on the wide compare.
module ptc_cmp #(
   parameter int unsigned TW        = 64,
   parameter bit          REG_STAGE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic [TW-1:0] now,
   input  logic [TW-1:0] target,
   output logic          hit
);
   logic ge;
   logic level;
   logic level_q;

   assign ge = (now >= target);

   generate
      if (REG_STAGE) begin : g_piped
         logic ge_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ge_r <= 1'b0;
            else if (hold) ge_r <= 1'b0;
            else           ge_r <= ge;
         end
         assign level = ge_r;
      end else begin : g_direct
         assign level = ge;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    level_q <= 1'b0;
      else if (hold) level_q <= 1'b0;
      else           level_q <= level;
   end

   assign hit = level & ~level_q;
endmodule

// File: rtl/ptc_top.sv
module ptc_top
   import ptc_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter logic [31:0] DEF_ADDEND = 32'hA000_0000,
   parameter bit          CMP_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tgt_hit
);
   localparam int unsigned TIME_W = 2 * DATA_W;
   localparam logic [DATA_W-1:0] ADD_RST = DEF_ADDEND[DATA_W-1:0];
   localparam logic [TIME_W-1:0] TGT_RST = {{(TIME_W-1){1'b0}}, 1'b1};

   generate
      if (DATA_W < 8 || DATA_W > 32) begin : g_bad_width
         $error("ptc_top: DATA_W must lie in 8..32");
      end
   endgenerate

   logic              hold;
   logic [DATA_W-1:0] addend_q;
   logic              lomax_en_q;
   logic [DATA_W-1:0] lomax_q;
   logic [TIME_W-1:0] tgt_q;
   logic [DATA_W-1:0] pend_lo_q;
   logic [DATA_W-1:0] shadow_hi_q;
   logic [DATA_W-1:0] acc_q;
   logic              acc_carry;
   logic [DATA_W-1:0] time_lo;
   logic [DATA_W-1:0] time_hi;
   logic [TIME_W-1:0] time_now;
   logic              time_ld;
   logic              rd_lo;

   logic wr_ctrl, wr_add, wr_acc, wr_tlo, wr_thi, wr_glo, wr_ghi, wr_men, wr_max;
   always_comb begin
      wr_ctrl = bus_wr && (bus_addr == A_CTRL);
      wr_add  = bus_wr && (bus_addr == A_ADDEND)  && !hold;
      wr_acc  = bus_wr && (bus_addr == A_ACCUM)   && !hold;
      wr_tlo  = bus_wr && (bus_addr == A_TIME_LO) && !hold;
      wr_thi  = bus_wr && (bus_addr == A_TIME_HI) && !hold;
      wr_glo  = bus_wr && (bus_addr == A_TGT_LO)  && !hold;
      wr_ghi  = bus_wr && (bus_addr == A_TGT_HI)  && !hold;
      wr_men  = bus_wr && (bus_addr == A_MAX_EN)  && !hold;
      wr_max  = bus_wr && (bus_addr == A_MAX)     && !hold && lomax_en_q;
      rd_lo   = bus_rd && (bus_addr == A_TIME_LO) && !hold;
      time_ld = wr_thi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold <= 1'b0;
      else if (wr_ctrl) hold <= bus_wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || hold) begin
         addend_q    <= ADD_RST;
         lomax_en_q  <= 1'b0;
         lomax_q     <= '1;
         tgt_q       <= TGT_RST;
         pend_lo_q   <= '0;
         shadow_hi_q <= '0;
      end else begin
         if (wr_add) addend_q   <= bus_wdata;
         if (wr_men) lomax_en_q <= bus_wdata[0];
         if (wr_max) lomax_q    <= bus_wdata;
         if (wr_glo) tgt_q[DATA_W-1:0]      <= bus_wdata;
         if (wr_ghi) tgt_q[TIME_W-1:DATA_W] <= bus_wdata;
         if (wr_tlo) pend_lo_q   <= bus_wdata;
         if (rd_lo)  shadow_hi_q <= time_hi;
      end
   end

   ptc_accum #(.W(DATA_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .hold(hold), .addend(addend_q),
      .acc_wr(wr_acc), .acc_wdata(bus_wdata), .acc_q(acc_q), .carry(acc_carry)
   );

   ptc_timectr #(.W(DATA_W)) u_time (
      .clk(clk), .rst_n(rst_n), .hold(hold), .inc(acc_carry), .lomax(lomax_q),
      .ld(time_ld), .ld_val({bus_wdata, pend_lo_q}), .lo(time_lo), .hi(time_hi)
   );

   assign time_now = {time_hi, time_lo};

   ptc_cmp #(.TW(TIME_W), .REG_STAGE(CMP_REG)) u_cmp (
      .clk(clk), .rst_n(rst_n), .hold(hold), .now(time_now), .target(tgt_q), .hit(tgt_hit)
   );

   always_comb begin
      case (bus_addr)
         A_CTRL:    bus_rdata = {{(DATA_W-1){1'b0}}, hold};
         A_ADDEND:  bus_rdata = addend_q;
         A_ACCUM:   bus_rdata = acc_q;
         A_TIME_LO: bus_rdata = time_lo;
         A_TIME_HI: bus_rdata = shadow_hi_q;
         A_TGT_LO:  bus_rdata = tgt_q[DATA_W-1:0];
         A_TGT_HI:  bus_rdata = tgt_q[TIME_W-1:DATA_W];
         A_MAX_EN:  bus_rdata = {{(DATA_W-1){1'b0}}, lomax_en_q};
         A_MAX:     bus_rdata = lomax_q;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ptc_chk.sv
module ptc_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter logic [31:0] DEF_ADDEND = 32'hA000_0000,
   parameter bit          CMP_REG    = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                hold,
   input logic                inc,
   input logic                ld,
   input logic [DATA_W-1:0]   lo,
   input logic [DATA_W-1:0]   hi,
   input logic [DATA_W-1:0]   lomax,
   input logic                lomax_en,
   input logic [DATA_W-1:0]   addend,
   input logic                rd_lo,
   input logic [DATA_W-1:0]   shadow,
   input logic                hit,
   input logic [2*DATA_W-1:0] target
);
   // R2: time moves only on a carry, a load or the reset hold
   assert_time_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ({hi, lo} != $past({hi, lo})) |-> ($past(inc) || $past(ld) || $past(hold)));

   // R6: wrap at the programmed maximum
   assert_lo_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inc) && !$past(ld) && !$past(hold) && ($past(lo) == $past(lomax)))
      |-> (lo == '0 && hi == $past(hi) + 1'b1));

   // R7: maximum is frozen while its enable is clear
   assert_max_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(lomax_en) && !$past(hold)) |-> (lomax == $past(lomax)));

   // R4: a low-word read captures the high word
   assert_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_lo) && !$past(hold)) |-> (shadow == $past(hi)));

   // R8: target pulse lasts one cycle
   assert_hit_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);

   generate
      if (!CMP_REG) begin : g_direct_chk
         // R8: pulse only with time at or beyond target
         assert_hit_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> ({hi, lo} >= target));
      end
   endgenerate

   // R9: reset hold forces defaults
   assert_hold_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ({hi, lo} == '0 && addend == DEF_ADDEND[DATA_W-1:0] && lomax == '1 && !lomax_en));
endmodule

bind ptc_top ptc_chk #(.DATA_W(DATA_W), .DEF_ADDEND(DEF_ADDEND), .CMP_REG(CMP_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .hold(hold), .inc(acc_carry), .ld(time_ld),
   .lo(time_lo), .hi(time_hi), .lomax(lomax_q), .lomax_en(lomax_en_q),
   .addend(addend_q), .rd_lo(rd_lo), .shadow(shadow_hi_q), .hit(tgt_hit), .target(tgt_q)
);

// File: tb/tb_ptc_top.sv
module tb_ptc_top;
   import ptc_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tgt_hit;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ptc_top dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_hit(tgt_hit)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic t_reset;
      rd_chk("R1 addend", A_ADDEND, 32'hA000_0000);
      rd_chk("R1 tgt lo", A_TGT_LO, 32'd1);
      rd_chk("R1 tgt hi", A_TGT_HI, 32'd0);
      rd_chk("R1 max", A_MAX, 32'hFFFF_FFFF);
      rd_chk("R1 max en", A_MAX_EN, 32'd0);
      rd_chk("R1 ctrl", A_CTRL, 32'd0);
      rd_chk("R1 unused", 4'hC, 32'd0);
      check("R1 hit", {31'd0, tgt_hit}, 32'd0);
   endtask

   task automatic t_trim(input longint ppb);
      longint base = 64'hA000_0000;
      longint mag  = (ppb < 0) ? -ppb : ppb;
      longint diff = (base * mag) / 1000000000;
      logic [31:0] x = (ppb < 0) ? 32'(base - diff) : 32'(base + diff);
      wr(A_ADDEND, 32'd0);
      wr(A_ACCUM, 32'd0);
      wr(A_ADDEND, x);
      rd_chk("R3 old addend on write edge", A_ACCUM, 32'd0);
      rd_chk("R2 accum one step", A_ACCUM, x);
      rd_chk("R2 accum two steps", A_ACCUM, x + x);
   endtask

   task automatic t_carry;
      wr(A_ADDEND, 32'd0);
      wr(A_TIME_LO, 32'h100);
      wr(A_TIME_HI, 32'd0);
      wr(A_ACCUM, 32'h6000_0000);
      wr(A_ADDEND, 32'hA000_0000);
      rd_chk("R10 accum written", A_ACCUM, 32'h6000_0000);
      rd_chk("R2 carry increments time", A_TIME_LO, 32'h101);
      rd_chk("R2 accum after carry", A_ACCUM, 32'hA000_0000);
   endtask

   task automatic t_coherent;
      wr(A_ADDEND, 32'd0);
      wr(A_ACCUM, 32'hFFFF_FFFF);
      wr(A_TIME_LO, 32'hFFFF_FFFE);
      wr(A_TIME_HI, 32'd5);
      wr(A_ADDEND, 32'hFFFF_FFFF);
      rd_chk("R5 loaded low", A_TIME_LO, 32'hFFFF_FFFE);
      @(negedge clk);
      rd_chk("R4 shadow high", A_TIME_HI, 32'd5);
      rd_chk("R6 low wrapped", A_TIME_LO, 32'd1);
      rd_chk("R4 high after wrap", A_TIME_HI, 32'd6);
   endtask

   task automatic t_lomax;
      wr(A_ADDEND, 32'd0);
      wr(A_MAX, 32'd9);
      rd_chk("R7 locked max", A_MAX, 32'hFFFF_FFFF);
      wr(A_MAX_EN, 32'd1);
      wr(A_MAX, 32'd9);
      wr(A_MAX_EN, 32'd0);
      rd_chk("R7 unlocked write", A_MAX, 32'd9);
      wr(A_ACCUM, 32'hFFFF_FFFF);
      wr(A_TIME_LO, 32'd8);
      wr(A_TIME_HI, 32'h10);
      wr(A_ADDEND, 32'hFFFF_FFFF);
      rd_chk("R5 low before max", A_TIME_LO, 32'd8);
      @(negedge clk);
      rd_chk("R6 wrap at max", A_TIME_LO, 32'd0);
      rd_chk("R6 high incremented", A_TIME_HI, 32'h11);
   endtask

   task automatic t_softrst;
      wr(A_CTRL, 32'd1);
      wr(A_ADDEND, 32'd5);
      rd_chk("R9 write ignored", A_ADDEND, 32'hA000_0000);
      rd_chk("R9 time held", A_TIME_LO, 32'd0);
      rd_chk("R9 target default", A_TGT_LO, 32'd1);
      rd_chk("R9 max default", A_MAX, 32'hFFFF_FFFF);
      rd_chk("R9 ctrl set", A_CTRL, 32'd1);
      wr(A_CTRL, 32'd0);
      rd_chk("R9 accum at release", A_ACCUM, 32'd0);
      rd_chk("R9 default addend runs", A_ACCUM, 32'hA000_0000);
      rd_chk("R9 time resumes", A_TIME_LO, 32'd1);
   endtask

   task automatic t_target(input logic [31:0] glo, input logic [31:0] ghi,
                           input logic [31:0] tlo, input logic [31:0] thi, input int at);
      wr(A_ADDEND, 32'd0);
      wr(A_ACCUM, 32'hFFFF_FFFF);
      wr(A_TGT_LO, glo);
      wr(A_TGT_HI, ghi);
      wr(A_TIME_LO, tlo);
      wr(A_TIME_HI, thi);
      wr(A_ADDEND, 32'hFFFF_FFFF);
      for (int k = 0; k < 6; k++) begin
         #1 check("R8 target pulse", {31'd0, tgt_hit}, (k == at) ? 32'd1 : 32'd0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_trim(1000000);
      t_trim(-50000000);
      t_carry();
      t_coherent();
      t_lomax();
      t_softrst();
      t_target(32'd100, 32'd0, 32'd97, 32'd0, 3);
      t_target(32'd0, 32'd1, 32'hFFFF_FFFE, 32'd0, 2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule